// File: doc/BRIEF.md
# Frequency Boost and Target Calculator

This block turns the results of an activity monitor into a clock-frequency request. Each command starts one calculation. The command either restarts the governor state or reports the consecutive-breach events from the last sampling window. The block keeps a boost value. It raises the boost with a percentage gain plus a fixed step while the load stays above the upper window, and it shrinks the boost by a percentage while the load stays below the lower window. It also returns the enable bits that tell the monitor which consecutive-breach direction to watch next.

Each calculation runs after a single start pulse. All operands are captured on that pulse. The block then computes the raw upper and lower watermarks from the current frequency, the sampling period and the two threshold percentages. It derives an upper and a lower average watermark around the sampled average, with a band scaled from the maximum frequency. Finally it produces a target frequency, which is the per-period average rescaled by the upper threshold plus the boost. One shared multi-cycle divider handles every division. Results appear together in the cycle that `done` is high and are held until the next command completes.

Top module: `freq_boost_calc`

## Requirements
- R1: After reset, `boost`, `target` and all four watermarks are 0. `en_above` is 1 and `en_below` is 0. `busy` and `done` are 0.
- R2: A `start` seen while `busy` is 0 captures every data input and raises `busy` in the next cycle. A `start` while `busy` is 1 is ignored, and input changes after the capture have no effect. `done` is high for exactly one cycle, with `busy` low. No output changes in any cycle where `done` is low.
- R3: Upper event (`evt_up`=1, `restart`=0). The new boost is the 32-bit-saturated value of boost×`up_coeff`/100, plus 16000. If the new boost is greater than or equal to `max_freq`, it becomes `max_freq` and `en_above` becomes 0; otherwise `en_above` keeps its value. `en_below` becomes 1.
- R4: Lower event (`evt_dn`=1, `evt_up`=0, `restart`=0). The new boost is the 32-bit-saturated value of boost×`down_coeff`/100, and `en_above` becomes 1. If the new boost is below 8000, it becomes 0 and `en_below` becomes 0; otherwise `en_below` keeps its value.
- R5: When both event flags are 1, only the upper-event rule of R3 applies.
- R6: When `restart`=1, the event flags are ignored. Boost becomes 0, `en_above` becomes 1 and `en_below` becomes 0. The average used for this command is `cur_freq`×`period`, saturated to 32 bits, and `avg_in` is ignored.
- R7: When `restart`=0 and both flags are 0, boost and both enables keep their values.
- R8: Every percentage product divided by 100 saturates at 2^32−1 before any later addition or comparison.
- R9: `wm_upper` = `cur_freq`×`period`×`up_thr`/100 and `wm_lower` = `cur_freq`×`period`×`down_thr`/100. Both are computed at full width and saturated to 32 bits.
- R10: The band is (`max_freq`×6/1000)×`period`, saturated to 32 bits. `avg_upper` is average+band, saturated at 2^32−1. `avg_lower` is average−band, floored at 0.
- R11: `target` = sat32(sat32(average/`period`)×(10000/`up_thr`)/100) + boost, saturated at 2^32−1. The boost used is the value after this command's update. `period` and `up_thr` must be nonzero.
- R12: Whenever `en_below` is 0, `boost` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one calculation; accepted when idle |
| restart | input | 1 | Governor restart command instead of an event report |
| evt_up | input | 1 | Consecutive-upper breach reported |
| evt_dn | input | 1 | Consecutive-lower breach reported |
| avg_in | input | 32 | Sampled average activity count |
| cur_freq | input | 32 | Current frequency |
| max_freq | input | 32 | Maximum frequency |
| period | input | 9 | Sampling period, 1 to 256 |
| up_coeff | input | 16 | Boost growth percentage |
| down_coeff | input | 16 | Boost decay percentage |
| up_thr | input | 8 | Upper threshold percentage |
| down_thr | input | 8 | Lower threshold percentage |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse; outputs updated |
| boost | output | 32 | Boost value |
| target | output | 32 | Requested frequency |
| wm_upper | output | 32 | Raw upper watermark |
| wm_lower | output | 32 | Raw lower watermark |
| avg_upper | output | 32 | Average upper watermark |
| avg_lower | output | 32 | Average lower watermark |
| en_above | output | 1 | Enable for the upper consecutive-breach watch |
| en_below | output | 1 | Enable for the lower consecutive-breach watch |

## Verification
The bench builds the block with its default step of 16000 and a band of six per mille. The package fixes a 64-bit dividend, 16-bit coefficients and a 9-bit period. With these widths, a 65535-percent growth coefficient pushes the scaled boost beyond 32 bits within three upper events, so the saturation and clamp paths can be reached. With a maximum frequency of 2^32−1 and a period of 256, the band itself saturates, which drives the average upper watermark to its ceiling and floors the lower one. A realistic coefficient set carries the boost through its full climb to the clamp and its decay back to zero, and it toggles both enables along the way.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int unsigned FREQ_W     = 32;
    localparam int unsigned PER_W      = 9;
    localparam int unsigned COEF_W     = 16;
    localparam int unsigned THR_W      = 8;
    localparam int unsigned WIDE_W     = 64;
    localparam int unsigned PCT        = 100;
    localparam int unsigned PERMILLE   = 1000;
    localparam int unsigned PCT_SQUARE = 10000;

    typedef enum logic [3:0] {
        ST_IDLE, ST_BOOST, ST_WHI, ST_WLO, ST_BAND,
        ST_AVGQ, ST_COEF, ST_TGT, ST_FIN
    } phase_t;

    typedef struct packed {
        logic              init;
        logic              up;
        logic              dn;
        logic [FREQ_W-1:0] avg;
        logic [FREQ_W-1:0] cur;
        logic [FREQ_W-1:0] mx;
        logic [PER_W-1:0]  per;
        logic [COEF_W-1:0] uc;
        logic [COEF_W-1:0] dc;
        logic [THR_W-1:0]  ut;
        logic [THR_W-1:0]  dt;
    } req_t;

    function automatic logic [FREQ_W-1:0] sat_f(input logic [WIDE_W-1:0] v);
        return (|v[WIDE_W-1:FREQ_W]) ? '1 : v[FREQ_W-1:0];
    endfunction

    function automatic phase_t next_phase(input phase_t p);
        case (p)
            ST_BOOST: return ST_WHI;
            ST_WHI:   return ST_WLO;
            ST_WLO:   return ST_BAND;
            ST_BAND:  return ST_AVGQ;
            ST_AVGQ:  return ST_COEF;
            ST_COEF:  return ST_TGT;
            ST_TGT:   return ST_FIN;
            default:  return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/fbc_divider.sv
module fbc_divider #(
    parameter int unsigned NUM_W = 64,
    parameter int unsigned DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int unsigned CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] sh_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem_q, sh_q[NUM_W-1]};
    assign fits  = (trial >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                sh_q  <= num;
                den_q <= den;
                rem_q <= '0;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                sh_q  <= {sh_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(NUM_W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = sh_q;
endmodule

// File: rtl/fbc_boost_rule.sv
module fbc_boost_rule
    import fbc_pkg::*;
#(
    parameter int unsigned BOOST_STEP = 16000
) (
    input  logic              init,
    input  logic              up,
    input  logic              dn,
    input  logic [FREQ_W-1:0] scaled,
    input  logic [FREQ_W-1:0] boost_cur,
    input  logic [FREQ_W-1:0] mx,
    input  logic              ea_cur,
    input  logic              eb_cur,
    output logic [FREQ_W-1:0] boost_nx,
    output logic              ea_nx,
    output logic              eb_nx
);
    localparam int unsigned FLOOR = BOOST_STEP / 2;

    logic [FREQ_W:0] grown;
    assign grown = (FREQ_W+1)'(scaled) + (FREQ_W+1)'(BOOST_STEP);

    always_comb begin
        boost_nx = boost_cur;
        ea_nx    = ea_cur;
        eb_nx    = eb_cur;
        if (init) begin
            boost_nx = '0;
            ea_nx    = 1'b1;
            eb_nx    = 1'b0;
        end else if (up) begin
            eb_nx = 1'b1;
            if (grown >= {1'b0, mx}) begin
                boost_nx = mx;
                ea_nx    = 1'b0;
            end else begin
                boost_nx = grown[FREQ_W-1:0];
            end
        end else if (dn) begin
            ea_nx = 1'b1;
            if (scaled < FREQ_W'(FLOOR)) begin
                boost_nx = '0;
                eb_nx    = 1'b0;
            end else begin
                boost_nx = scaled;
            end
        end
    end
endmodule

// File: rtl/freq_boost_calc.sv
module freq_boost_calc
    import fbc_pkg::*;
#(
    parameter int unsigned BOOST_STEP    = 16000,
    parameter int unsigned BAND_PERMILLE = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              restart,
    input  logic              evt_up,
    input  logic              evt_dn,
    input  logic [FREQ_W-1:0] avg_in,
    input  logic [FREQ_W-1:0] cur_freq,
    input  logic [FREQ_W-1:0] max_freq,
    input  logic [PER_W-1:0]  period,
    input  logic [COEF_W-1:0] up_coeff,
    input  logic [COEF_W-1:0] down_coeff,
    input  logic [THR_W-1:0]  up_thr,
    input  logic [THR_W-1:0]  down_thr,
    output logic              busy,
    output logic              done,
    output logic [FREQ_W-1:0] boost,
    output logic [FREQ_W-1:0] target,
    output logic [FREQ_W-1:0] wm_upper,
    output logic [FREQ_W-1:0] wm_lower,
    output logic [FREQ_W-1:0] avg_upper,
    output logic [FREQ_W-1:0] avg_lower,
    output logic              en_above,
    output logic              en_below
);
    phase_t            ph_q;
    req_t              req_q;
    logic              go_q;
    logic              done_q;
    logic [WIDE_W-1:0] div_num;
    logic [FREQ_W-1:0] div_den;
    logic              div_done;
    logic [WIDE_W-1:0] div_quo;
    logic [FREQ_W-1:0] quo_sat;

    logic [FREQ_W-1:0] boost_q, whi_q, wlo_q, bandq_q, avgq_q, coef_q, tq_q;
    logic              ea_q, eb_q;
    logic [FREQ_W-1:0] nx_boost;
    logic              nx_ea, nx_eb;

    logic [WIDE_W-1:0] cur_per;
    logic [FREQ_W-1:0] avg_eff, band, ahi, alo, tgt;

    logic [FREQ_W-1:0] o_boost, o_tgt, o_whi, o_wlo, o_ahi, o_alo;
    logic              o_ea, o_eb;

    assign quo_sat = sat_f(div_quo);
    assign cur_per = WIDE_W'(req_q.cur) * WIDE_W'(req_q.per);
    assign avg_eff = req_q.init ? sat_f(cur_per) : req_q.avg;

    always_comb begin
        div_num = '0;
        div_den = FREQ_W'(PCT);
        case (ph_q)
            ST_BOOST: div_num = WIDE_W'(boost_q) * WIDE_W'(req_q.up ? req_q.uc : req_q.dc);
            ST_WHI:   div_num = cur_per * WIDE_W'(req_q.ut);
            ST_WLO:   div_num = cur_per * WIDE_W'(req_q.dt);
            ST_BAND: begin
                div_num = WIDE_W'(req_q.mx) * WIDE_W'(BAND_PERMILLE);
                div_den = FREQ_W'(PERMILLE);
            end
            ST_AVGQ: begin
                div_num = WIDE_W'(avg_eff);
                div_den = FREQ_W'(req_q.per);
            end
            ST_COEF: begin
                div_num = WIDE_W'(PCT_SQUARE);
                div_den = FREQ_W'(req_q.ut);
            end
            ST_TGT:   div_num = WIDE_W'(avgq_q) * WIDE_W'(coef_q);
            default: ;
        endcase
    end

    fbc_divider #(.NUM_W(WIDE_W), .DEN_W(FREQ_W)) div_i (
        .clk(clk), .rst(rst), .go(go_q), .num(div_num), .den(div_den),
        .done(div_done), .quo(div_quo)
    );

    fbc_boost_rule #(.BOOST_STEP(BOOST_STEP)) rule_i (
        .init(req_q.init), .up(req_q.up), .dn(req_q.dn), .scaled(quo_sat),
        .boost_cur(boost_q), .mx(req_q.mx), .ea_cur(ea_q), .eb_cur(eb_q),
        .boost_nx(nx_boost), .ea_nx(nx_ea), .eb_nx(nx_eb)
    );

    always_comb begin
        band = sat_f(WIDE_W'(bandq_q) * WIDE_W'(req_q.per));
        ahi  = sat_f(WIDE_W'(avg_eff) + WIDE_W'(band));
        alo  = (avg_eff > band) ? (avg_eff - band) : '0;
        tgt  = sat_f(WIDE_W'(tq_q) + WIDE_W'(boost_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= ST_IDLE;
            req_q   <= '0;
            go_q    <= 1'b0;
            done_q  <= 1'b0;
            boost_q <= '0;
            ea_q    <= 1'b1;
            eb_q    <= 1'b0;
            whi_q   <= '0;
            wlo_q   <= '0;
            bandq_q <= '0;
            avgq_q  <= '0;
            coef_q  <= '0;
            tq_q    <= '0;
            o_boost <= '0;
            o_tgt   <= '0;
            o_whi   <= '0;
            o_wlo   <= '0;
            o_ahi   <= '0;
            o_alo   <= '0;
            o_ea    <= 1'b1;
            o_eb    <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            if (ph_q == ST_IDLE) begin
                if (start) begin
                    req_q <= '{init: restart, up: evt_up, dn: evt_dn, avg: avg_in,
                               cur: cur_freq, mx: max_freq, per: period,
                               uc: up_coeff, dc: down_coeff, ut: up_thr, dt: down_thr};
                    ph_q  <= ST_BOOST;
                    go_q  <= 1'b1;
                end
            end else if (ph_q == ST_FIN) begin
                o_boost <= boost_q;
                o_ea    <= ea_q;
                o_eb    <= eb_q;
                o_whi   <= whi_q;
                o_wlo   <= wlo_q;
                o_ahi   <= ahi;
                o_alo   <= alo;
                o_tgt   <= tgt;
                done_q  <= 1'b1;
                ph_q    <= ST_IDLE;
            end else if (div_done) begin
                case (ph_q)
                    ST_BOOST: begin
                        boost_q <= nx_boost;
                        ea_q    <= nx_ea;
                        eb_q    <= nx_eb;
                    end
                    ST_WHI:  whi_q   <= quo_sat;
                    ST_WLO:  wlo_q   <= quo_sat;
                    ST_BAND: bandq_q <= quo_sat;
                    ST_AVGQ: avgq_q  <= quo_sat;
                    ST_COEF: coef_q  <= quo_sat;
                    ST_TGT:  tq_q    <= quo_sat;
                    default: ;
                endcase
                ph_q <= next_phase(ph_q);
                go_q <= (next_phase(ph_q) != ST_FIN);
            end
        end
    end

    assign busy      = (ph_q != ST_IDLE);
    assign done      = done_q;
    assign boost     = o_boost;
    assign target    = o_tgt;
    assign wm_upper  = o_whi;
    assign wm_lower  = o_wlo;
    assign avg_upper = o_ahi;
    assign avg_lower = o_alo;
    assign en_above  = o_ea;
    assign en_below  = o_eb;
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] boost,
    input logic [31:0] target,
    input logic [31:0] wm_upper,
    input logic [31:0] avg_upper,
    input logic [31:0] avg_lower,
    input logic        en_below
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(boost) && $stable(target) && $stable(wm_upper)));

    // R12
    zero_boost_chk: assert property (@(posedge clk) disable iff (rst)
        !en_below |-> (boost == 32'd0));

    // R10
    avg_order_chk: assert property (@(posedge clk) disable iff (rst)
        avg_lower <= avg_upper);
endmodule

bind freq_boost_calc fbc_checker chk_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .boost(boost), .target(target), .wm_upper(wm_upper),
    .avg_upper(avg_upper), .avg_lower(avg_lower), .en_below(en_below)
);

// File: tb/freq_boost_calc_tb_top.sv
`timescale 1ns/1ps
module freq_boost_calc_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, restart = 1'b0, evt_up = 1'b0, evt_dn = 1'b0;
    logic [31:0] avg_in = '0, cur_freq = '0, max_freq = '0;
    logic [8:0]  period = '0;
    logic [15:0] up_coeff = '0, down_coeff = '0;
    logic [7:0]  up_thr = '0, down_thr = '0;
    logic        busy, done, en_above, en_below;
    logic [31:0] boost, target, wm_upper, wm_lower, avg_upper, avg_lower;

    int checks = 0;
    int errors = 0;
    bit armed = 0;
    string cur_tag = "R1";

    // reference state
    longint e_boost = 0, e_tgt = 0, e_whi = 0, e_wlo = 0, e_ahi = 0, e_alo = 0;
    longint e_ea = 1, e_eb = 0;
    // pending command
    bit     p_init, p_up, p_dn;
    longint p_avg, p_cur, p_max, p_per, p_uc, p_dc, p_ut, p_dt;

    localparam longint MAX32 = 64'h0000_0000_FFFF_FFFF;

    always #2.5 clk = ~clk;

    freq_boost_calc dut_i (
        .clk(clk), .rst(rst), .start(start), .restart(restart), .evt_up(evt_up),
        .evt_dn(evt_dn), .avg_in(avg_in), .cur_freq(cur_freq), .max_freq(max_freq),
        .period(period), .up_coeff(up_coeff), .down_coeff(down_coeff),
        .up_thr(up_thr), .down_thr(down_thr), .busy(busy), .done(done),
        .boost(boost), .target(target), .wm_upper(wm_upper), .wm_lower(wm_lower),
        .avg_upper(avg_upper), .avg_lower(avg_lower), .en_above(en_above),
        .en_below(en_below)
    );

    function automatic longint sat(input longint v);
        return (v > MAX32) ? MAX32 : v;
    endfunction

    task automatic chk(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic model_apply();
        longint p, avg, band, q1, coef;
        if (p_init) begin
            e_boost = 0; e_ea = 1; e_eb = 0;
            avg = sat(p_cur * p_per);
        end else begin
            avg = p_avg;
            if (p_up) begin
                p = sat(e_boost * p_uc / 100) + 16000;
                e_eb = 1;
                if (p >= p_max) begin e_boost = p_max; e_ea = 0; end
                else e_boost = p;
            end else if (p_dn) begin
                p = sat(e_boost * p_dc / 100);
                e_ea = 1;
                if (p < 8000) begin e_boost = 0; e_eb = 0; end
                else e_boost = p;
            end
        end
        e_whi = sat(p_cur * p_per * p_ut / 100);
        e_wlo = sat(p_cur * p_per * p_dt / 100);
        band  = sat((p_max * 6 / 1000) * p_per);
        e_ahi = sat(avg + band);
        e_alo = (avg > band) ? avg - band : 0;
        q1    = sat(avg / p_per);
        coef  = 10000 / p_ut;
        e_tgt = sat(sat(q1 * coef / 100) + e_boost);
    endtask

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && armed) begin
            if (done) begin
                model_apply();
                chk(cur_tag, "boost", longint'(boost), e_boost);
                chk(cur_tag, "en_above", longint'(en_above), e_ea);
                chk(cur_tag, "en_below", longint'(en_below), e_eb);
                chk("R9", "wm_upper", longint'(wm_upper), e_whi);
                chk("R9", "wm_lower", longint'(wm_lower), e_wlo);
                chk("R10", "avg_upper", longint'(avg_upper), e_ahi);
                chk("R10", "avg_lower", longint'(avg_lower), e_alo);
                chk("R11", "target", longint'(target), e_tgt);
                chk("R2", "busy_at_done", longint'(busy), 0);
                if (en_below == 1'b0) chk("R12", "boost_when_below_off", longint'(boost), 0);
            end else begin
                chk("R2", "outputs_held",
                    longint'({boost, target, wm_upper, wm_lower} != {e_boost[31:0], e_tgt[31:0], e_whi[31:0], e_wlo[31:0]}
                     || {avg_upper, avg_lower} != {e_ahi[31:0], e_alo[31:0]}
                     || en_above != e_ea[0] || en_below != e_eb[0]), 0);
            end
        end
    end

    task automatic set_cfg(input longint cur, input longint mx, input longint per,
                           input longint uc, input longint dc, input longint ut, input longint dt);
        cur_freq = cur[31:0]; max_freq = mx[31:0]; period = per[8:0];
        up_coeff = uc[15:0]; down_coeff = dc[15:0]; up_thr = ut[7:0]; down_thr = dt[7:0];
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        if (!seen) begin
            checks++; errors++;
            $display("FAIL R2 done_timeout actual=0 expected=1");
        end
        @(posedge clk); #1;
    endtask

    task automatic issue(input bit ini, input bit up, input bit dn, input longint avg,
                         input string tag, input bit probe);
        cur_tag = tag;
        restart = ini; evt_up = up; evt_dn = dn; avg_in = avg[31:0];
        p_init = ini; p_up = up; p_dn = dn; p_avg = avg;
        p_cur = cur_freq; p_max = max_freq; p_per = period;
        p_uc = up_coeff; p_dc = down_coeff; p_ut = up_thr; p_dt = down_thr;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (probe) begin
            // R2: a second start while busy, and altered inputs, must be ignored
            repeat (3) @(posedge clk);
            #1;
            chk("R2", "busy_after_start", longint'(busy), 1);
            restart = 1'b1; evt_up = 1'b1; avg_in = 32'd77; cur_freq = 32'd5;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        wait_done();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "boost", longint'(boost), 0);
        chk("R1", "target", longint'(target), 0);
        chk("R1", "watermarks", longint'(wm_upper | wm_lower | avg_upper | avg_lower), 0);
        chk("R1", "en_above", longint'(en_above), 1);
        chk("R1", "en_below", longint'(en_below), 0);
        chk("R1", "busy_done", longint'({busy, done}), 0);
        armed = 1;
        @(posedge clk); #1;

        set_cfg(400000, 600000, 12, 200, 50, 60, 40);
        issue(1, 1, 0, 123, "R6", 0);                 // restart ignores flags and avg_in
        for (int k = 0; k < 7; k++) issue(0, 1, 0, 2000000 + k * 1000, "R3", 0);
        for (int k = 0; k < 9; k++) issue(0, 0, 1, 1500000 - k * 1000, "R4", 0);
        issue(0, 1, 1, 3000000, "R5", 0);              // both flags: upper wins
        issue(0, 1, 1, 3100000, "R5", 0);
        issue(0, 0, 0, 2500000, "R7", 0);              // no event: unchanged
        set_cfg(250000, 600000, 40, 200, 50, 27, 10);
        issue(0, 0, 0, 9000000, "R7", 0);
        issue(0, 0, 1, 8000000, "R2", 1);              // start during busy ignored
        issue(0, 0, 0, 100, "R10", 0);                 // band exceeds avg: floor at 0

        set_cfg(400000, 64'hFFFF_FFFF, 256, 65535, 50, 1, 99);
        issue(1, 0, 0, 0, "R6", 0);
        for (int k = 0; k < 3; k++) issue(0, 1, 0, 64'hFFFF_FF00, "R8", 0);
        issue(0, 0, 0, 64'hFFFF_FFF0, "R10", 0);

        set_cfg(1000, 600000, 1, 200, 50, 3, 1);
        issue(0, 0, 1, 5000, "R4", 0);
        issue(0, 0, 0, 77777, "R11", 0);

        repeat (3) @(posedge clk);
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end
endmodule